// File: doc/BRIEF.md
# Polarity-Selectable Phase-Frequency Detector

This block compares two divided pulse trains inside a frequency synthesizer: a reference stream and a feedback stream. Everything is sampled on a single system clock. A rising edge on either stream sets that stream's capture flop. When both capture flops are set, a small coincidence counter holds them set for a programmable number of clocks and then clears them together. The capture flops therefore always overlap for a short minimum time on every comparison, so no small phase error is lost in a dead band.

The two captured states can drive one of two output styles. The first is a single-ended error drive with an output-enable, which a three-state pad would use. The second is a pair of active-low correction pulses. A detector-select bit chooses the style and pins the unused outputs to fixed idle levels. A polarity bit inverts the single-ended drive and exchanges the two active-low pulses, which lets the block serve loop filters and oscillators of either gain sign. A lock indicator rests high when no correction is pending, dips low while one is, and can be gated off. A jam-load strobe clears the detector whenever the dividers are reloaded.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rstN` is low, the registered polarity, detector-select and lock-enable bits are held at 0. The outputs are then `seOe`=0, `seDrive`=0, `refSideN`=1, `fbSideN`=1 and `lockDet`=0.
- R2: A rising edge on `refIn` (low on one clock sample, high on the next) sets the reference capture state at that clock edge. A rising edge on `fbIn` sets the feedback capture state in the same way. A level that stays high causes no further set.
- R3: Once both capture states are set, they stay set together for exactly `resetDelay`+1 clocks and then clear on the same edge. A rising edge that arrives at that clearing edge sets its own state again.
- R4: `jamLoad` high at a clock edge clears both capture states and the coincidence count, and it overrides any rising edge seen at that same edge.
- R5: With detector-select at 1 and polarity at 0, these outputs apply. Only the feedback state set gives `seOe`=1 and `seDrive`=0. Only the reference state set gives `seOe`=1 and `seDrive`=1. Neither or both set gives `seOe`=0. `seDrive` is 0 whenever `seOe` is 0.
- R6: Polarity at 1 inverts the driven level of `seDrive` while `seOe` is 1.
- R7: With detector-select at 0 and polarity at 0, `refSideN` is the inverse of the reference state and `fbSideN` is the inverse of the feedback state. With polarity at 1, the two outputs exchange their sources.
- R8: Detector-select at 1 forces both `refSideN` and `fbSideN` to 1. Detector-select at 0 forces `seOe` and `seDrive` to 0.
- R9: `lockDet` is 1 only when lock-enable is 1 and neither capture state is set. Lock-enable at 0 holds it at 0.
- R10: `polSel`, `detSel` and `lockEn` are registered. A change takes effect at the outputs one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Divided reference pulse train |
| fbIn | input | 1 | Divided feedback pulse train |
| jamLoad | input | 1 | Divider reload strobe; clears the detector |
| polSel | input | 1 | Polarity select |
| detSel | input | 1 | 1 = single-ended drive, 0 = active-low pulse pair |
| lockEn | input | 1 | Lock indicator enable |
| resetDelay | input | DLY_W | Extra clocks of coincidence before both states clear |
| seDrive | output | 1 | Single-ended drive level |
| seOe | output | 1 | Single-ended output enable |
| refSideN | output | 1 | Active-low reference-side correction pulse |
| fbSideN | output | 1 | Active-low feedback-side correction pulse |
| lockDet | output | 1 | Lock indicator |

## Verification
The hardest condition to reach from the ports is a fresh rising edge that lands on the exact edge where the coincidence counter clears both states. Only that case exercises the re-set rule of R3. The bench reaches it by running the two trains at different periods with short non-zero delays, so their relative phase sweeps through every alignment. A cycle-accurate behavioural model checks each clock. Directed sequences pin down the overlap width at two delay settings, the one-clock configuration latency, and a jam that lands while a capture state is set.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes from the control half to the capture flops.
  typedef struct packed {
    logic setRef;
    logic setFb;
    logic clrBoth;
  } pfdStrobe_t;

  // Configuration bits as seen by the datapath.
  typedef struct packed {
    logic pol;
    logic detSel;
    logic lockEn;
  } pfdCfg_t;

  localparam int SIDE_REF = 0;
  localparam int SIDE_FB  = 1;
  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic             jamLoad,
  input  logic [DLY_W-1:0] resetDelay,
  input  logic             refHeld,
  input  logic             fbHeld,
  output pfdStrobe_t       strobe
);

  logic             refPrev;
  logic             fbPrev;
  logic [DLY_W-1:0] coinCnt;
  logic             refRise;
  logic             fbRise;
  logic             bothHeld;
  logic             limitHit;

  // Edge detection on the sampled pulse trains.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  assign refRise  = refIn & ~refPrev;
  assign fbRise   = fbIn & ~fbPrev;
  assign bothHeld = refHeld & fbHeld;
  assign limitHit = bothHeld & (coinCnt == resetDelay);

  // Coincidence counter: runs while both states are held.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coinCnt <= '0;
    end else if (jamLoad || !bothHeld || limitHit) begin
      coinCnt <= '0;
    end else begin
      coinCnt <= coinCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.setRef  = refRise & ~jamLoad;
    strobe.setFb   = fbRise & ~jamLoad;
    strobe.clrBoth = jamLoad | limitHit;
  end

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  input  pfdCfg_t    cfgIn,
  output logic       refHeld,
  output logic       fbHeld,
  output logic       seDrive,
  output logic       seOe,
  output logic       refSideN,
  output logic       fbSideN,
  output logic       lockDet
);

  pfdCfg_t               cfgQ;
  logic [NUM_SIDES-1:0]  heldQ;
  logic [NUM_SIDES-1:0]  setVec;
  logic                  onlyOne;
  logic                  leadSide;
  logic                  lagSide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      cfgQ <= cfgIn;
    end
  end

  assign setVec[SIDE_REF] = strobe.setRef;
  assign setVec[SIDE_FB]  = strobe.setFb;

  // One capture flop per side; a clear keeps a coincident set.
  for (genvar gi = 0; gi < NUM_SIDES; gi++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldQ[gi] <= 1'b0;
      end else if (strobe.clrBoth) begin
        heldQ[gi] <= setVec[gi];
      end else begin
        heldQ[gi] <= heldQ[gi] | setVec[gi];
      end
    end
  end

  assign refHeld = heldQ[SIDE_REF];
  assign fbHeld  = heldQ[SIDE_FB];

  assign onlyOne  = heldQ[SIDE_REF] ^ heldQ[SIDE_FB];
  assign leadSide = cfgQ.pol ? heldQ[SIDE_FB] : heldQ[SIDE_REF];
  assign lagSide  = cfgQ.pol ? heldQ[SIDE_REF] : heldQ[SIDE_FB];

  always_comb begin
    if (cfgQ.detSel) begin
      seOe     = onlyOne;
      seDrive  = onlyOne & leadSide;
      refSideN = 1'b1;
      fbSideN  = 1'b1;
    end else begin
      seOe     = 1'b0;
      seDrive  = 1'b0;
      refSideN = ~leadSide;
      fbSideN  = ~lagSide;
    end
    lockDet = cfgQ.lockEn & ~(|heldQ);
  end

endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
  import pfd_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic             jamLoad,
  input  logic             polSel,
  input  logic             detSel,
  input  logic             lockEn,
  input  logic [DLY_W-1:0] resetDelay,
  output logic             seDrive,
  output logic             seOe,
  output logic             refSideN,
  output logic             fbSideN,
  output logic             lockDet
);

  pfdStrobe_t strobe;
  pfdCfg_t    cfgIn;
  logic       refHeld;
  logic       fbHeld;

  assign cfgIn.pol    = polSel;
  assign cfgIn.detSel = detSel;
  assign cfgIn.lockEn = lockEn;

  pfd_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .fbIn       (fbIn),
    .jamLoad    (jamLoad),
    .resetDelay (resetDelay),
    .refHeld    (refHeld),
    .fbHeld     (fbHeld),
    .strobe     (strobe)
  );

  pfd_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgIn    (cfgIn),
    .refHeld  (refHeld),
    .fbHeld   (fbHeld),
    .seDrive  (seDrive),
    .seOe     (seOe),
    .refSideN (refSideN),
    .fbSideN  (fbSideN),
    .lockDet  (lockDet)
  );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk,
  input logic rstN,
  input logic jamLoad,
  input logic detSel,
  input logic lockEn,
  input logic seDrive,
  input logic seOe,
  input logic refSideN,
  input logic fbSideN,
  input logic lockDet
);

  // R8: single-ended choice pins the pulse pair idle one edge later
  p_pulse_forced_r8: assert property (@(posedge clk) disable iff (!rstN)
    detSel |=> (refSideN && fbSideN));

  // R8: pulse-pair choice releases the single-ended drive
  p_se_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    !detSel |=> (!seOe && !seDrive));

  // R9: lock indicator gated off
  p_lock_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lockEn |=> !lockDet);

  // R9: indicator high means no correction pulse is active
  p_lock_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockDet |-> (refSideN && fbSideN));

  // R4: jam leaves both sides cleared
  p_jam_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    jamLoad |=> (!seOe && refSideN && fbSideN && (lockDet == $past(lockEn))));

  // R5: no drive level without the enable
  p_drive_needs_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    seDrive |-> seOe);

endmodule

bind phase_freq_detector pfd_checker u_pfdChk (.*);

// File: tb/phase_freq_detector_bench.sv
`timescale 1ns/1ps
module phase_freq_detector_bench;

  localparam int DLY_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, fbIn = 1'b0, jamLoad = 1'b0;
  logic polSel = 1'b0, detSel = 1'b0, lockEn = 1'b0;
  logic [DLY_W-1:0] resetDelay = '0;
  logic seDrive, seOe, refSideN, fbSideN, lockDet;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_freq_detector #(.DLY_W(DLY_W)) u_phase_freq_detector (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .jamLoad(jamLoad),
    .polSel(polSel), .detSel(detSel), .lockEn(lockEn), .resetDelay(resetDelay),
    .seDrive(seDrive), .seOe(seOe), .refSideN(refSideN), .fbSideN(fbSideN),
    .lockDet(lockDet)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge.
  bit mUp, mDn, mPrevR, mPrevF, mPol, mDet, mLock, modelLive;
  int mCnt;

  always @(posedge clk) begin : mdl
    bit rr, fr, clr;
    if (!rstN) begin
      mUp = 0; mDn = 0; mCnt = 0; mPrevR = 0; mPrevF = 0;
      mPol = 0; mDet = 0; mLock = 0; modelLive = 1;
    end else begin
      rr = refIn && !mPrevR;
      fr = fbIn && !mPrevF;
      if (jamLoad) begin
        mUp = 0; mDn = 0; mCnt = 0;
      end else begin
        clr = mUp && mDn && (mCnt == int'(resetDelay));
        if (mUp && mDn && !clr) mCnt = mCnt + 1; else mCnt = 0;
        if (clr) begin mUp = rr; mDn = fr; end
        else begin mUp = mUp || rr; mDn = mDn || fr; end
      end
      mPrevR = refIn; mPrevF = fbIn;
      mPol = polSel; mDet = detSel; mLock = lockEn;
    end
  end

  // Compare on every falling edge once out of reset.
  always @(negedge clk) begin
    bit eOe, eDrv, eRn, eFn, eLk;
    if (rstN && modelLive && !done) begin
      eOe  = mDet && (mUp != mDn);
      eDrv = eOe && (mPol ? mDn : mUp);
      eRn  = mDet ? 1'b1 : !(mPol ? mDn : mUp);
      eFn  = mDet ? 1'b1 : !(mPol ? mUp : mDn);
      eLk  = mLock && !mUp && !mDn;
      chk(seOe == eOe, mDet ? "R5" : "R8", "seOe", seOe, eOe);
      chk(seDrive == eDrv, mPol ? "R6" : "R5", "seDrive", seDrive, eDrv);
      chk(refSideN == eRn, mDet ? "R8" : "R7", "refSideN", refSideN, eRn);
      chk(fbSideN == eFn, mDet ? "R8" : "R7", "fbSideN", fbSideN, eFn);
      chk(lockDet == eLk, "R9", "lockDet", lockDet, eLk);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic jam();
    jamLoad = 1; tick(1); jamLoad = 0;
  endtask

  // Overlap width measured on the lock indicator for in-phase edges (R3).
  task automatic overlapWidth(input int dly);
    int lowRun;
    resetDelay = dly[DLY_W-1:0];
    refIn = 0; fbIn = 0; tick(1); jam(); tick(1);
    refIn = 1; fbIn = 1; tick(1);
    lowRun = 0;
    for (int i = 0; i < 40; i++) begin
      if (!lockDet) lowRun++;
      tick(1);
    end
    chk(lowRun == dly + 1, "R3", "overlap clocks", lowRun, dly + 1);
    refIn = 0; fbIn = 0; tick(2);
  endtask

  task automatic trains(input int refPer, input int fbPer, input int fbOfs,
                        input int cycles, input bit midJam);
    for (int c = 0; c < cycles; c++) begin
      refIn = (c % refPer) < 2;
      fbIn  = ((c + fbPer * 50 - fbOfs) % fbPer) < 2;
      jamLoad = midJam && (c == cycles / 2);
      tick(1);
    end
    jamLoad = 0; refIn = 0; fbIn = 0;
    tick(3);
  endtask

  initial begin
    // R1: reset state with configuration inputs high
    polSel = 1; detSel = 1; lockEn = 1; refIn = 1;
    tick(3);
    chk(seOe == 0, "R1", "seOe", seOe, 0);
    chk(seDrive == 0, "R1", "seDrive", seDrive, 0);
    chk(refSideN == 1, "R1", "refSideN", refSideN, 1);
    chk(fbSideN == 1, "R1", "fbSideN", fbSideN, 1);
    chk(lockDet == 0, "R1", "lockDet", lockDet, 0);
    polSel = 0; detSel = 0; refIn = 0;
    tick(1);
    rstN = 1;
    tick(2);

    // R2: single reference edge, held level does not retrigger
    resetDelay = 2;
    refIn = 1; tick(1);
    chk(refSideN == 0, "R2", "refSideN after edge", refSideN, 0);
    chk(lockDet == 0, "R9", "lockDet while pending", lockDet, 0);
    tick(3);
    chk(refSideN == 0 && fbSideN == 1, "R2", "held level", refSideN, 0);

    // R10: polarity change seen one edge later
    polSel = 1; tick(1);
    chk(fbSideN == 0, "R10", "fbSideN after polarity", fbSideN, 0);
    chk(refSideN == 1, "R10", "refSideN after polarity", refSideN, 1);

    // R4: jam clears a set state; held level does not set it again
    jamLoad = 1; fbIn = 1; tick(1); jamLoad = 0;
    chk(fbSideN == 1 && refSideN == 1, "R4", "pulses after jam", fbSideN, 1);
    chk(lockDet == 1, "R4", "lockDet after jam", lockDet, 1);
    tick(2);
    chk(lockDet == 1, "R4", "still clear", lockDet, 1);
    refIn = 0; fbIn = 0; polSel = 0; tick(2);

    // R3: overlap width at two delay settings
    overlapWidth(0);
    overlapWidth(5);

    // Pulse trains under every polarity / detector choice
    resetDelay = 2;
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        polSel = p[0]; detSel = d[0]; lockEn = 1; tick(1);
        trains(20, 20, 0, 80, 0);   // matched
        trains(20, 20, 5, 80, 0);   // feedback lagging
        trains(20, 20, -5, 80, 0);  // feedback leading
        trains(20, 17, 0, 200, 1);  // feedback faster, jam mid-run
        trains(13, 16, 3, 200, 0);  // feedback slower
      end
    end
    // Sweeping phase with short delays reaches edges on the clearing cycle
    for (int dl = 0; dl < 4; dl++) begin
      resetDelay = dl[DLY_W-1:0];
      polSel = dl[0]; detSel = dl[1];
      trains(7, 9, 1, 400, 0);
      trains(5, 6, 2, 400, 1);
    end
    // R9: lock indicator disabled
    lockEn = 0; detSel = 0; tick(1);
    trains(11, 12, 0, 120, 0);
    chk(lockDet == 0, "R9", "lockDet disabled", lockDet, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule